// File: doc/BRIEF.md
# Universal Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor as two outputs. One is an ordinary interrupt and the other is a critical (machine-check class) interrupt. Each source can be set up on its own. Software chooses whether it is captured on a level or on an edge, which polarity counts as active, and which of the two outputs it drives. Captured requests are held in a status register until software clears them by writing ones to it. An enable register decides which held requests reach an output.

Software reaches the block through a simple single-cycle port. A write takes effect on the clock edge where `wrEn` is high. A read returns its data combinationally from `addr`. The port offers a masked-status view and a priority-encoded index of the most urgent pending enabled source. A configuration bit sets the direction of priority.

The register offsets are: 0x00 status, 0x04 enable, 0x08 route, 0x0C polarity, 0x10 trigger, 0x14 masked status, 0x18 priority configuration and 0x1C pending index. The masked-status and pending-index offsets are read-only.

Top module: `uic_top`

## Requirements
- R1: Source n (0..31) sits at bit 31−n of `irqIn` and of every per-source register. For example, source 0 is bit 31 and source 31 is bit 0.
- R2: After reset the registers hold these values:
  - status = 0, enable = 0, route = 0xFFFFFFFF, polarity = 0 and trigger = 0.
  - priority configuration = 1 and pending index = 32.
  - Both outputs are low.
- R3: Writing status (0x00) clears each bit written as 1 and leaves each bit written as 0 unchanged. A held bit never clears without such a write.
- R4: A source whose trigger bit is 0 is level-sensitive. Its status bit sets while the input is at the active level, and it sets again on the cycle after a clear if the input is still active.
- R5: A source whose trigger bit is 1 is edge-sensitive. Its status bit sets only on a transition into the active level, and it stays clear after a clear while the input holds active.
- R6: A polarity bit of 1 makes high (or a rising edge) active. A polarity bit of 0 makes low (or a falling edge) active.
- R7: Sources 17, 18 and 19 (bits 14, 13 and 12) never set a status bit. They read as 0 in status and in masked status.
- R8: Offset 0x14 reads status AND enable. Writes to 0x14 change nothing.
- R9: A route bit of 1 sends an enabled held source to `irqNormal`, and 0 sends it to `irqCrit`. Each output is registered and changes one clock after the masked status changes.
- R10: The pending index at 0x1C gives the lowest-numbered masked pending source when priority configuration bit 0 is 1. It gives the highest-numbered one when that bit is 0. It reads 32 when no masked bit is set.
- R11: An input change reaches the status register on the third rising clock edge after it is applied, because of a two-stage synchronizer.
- R12: A write takes effect only when `addr[1:0]` is 0. Reads ignore `addr[1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Raw request lines; bit 31−n is source n |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irqNormal | output | 1 | Registered normal interrupt, active high |
| irqCrit | output | 1 | Registered critical interrupt, active high |

## Verification
The bench clears a level source while its input is still active and expects the bit to come back one cycle later. A design that lets the clear win permanently would lose that request. It also clears an edge source while its input is still active and expects the bit to stay clear, which catches a design that treats edges as levels. Reserved sources are driven active with every enable bit set, so a design that forgets the reserved mask would show set bits and a wrong pending index. Both priority directions and the empty case are read from the index register, which exposes an encoder scanning the wrong way or using a wrong "none" code. The bench also measures the three-edge synchronizer latency exactly and swaps the routing of one source, so a missing flop stage or an inverted route bit shows up.

// File: rtl/uic_pkg.sv
package uic_pkg;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_ROUTE  = 3'd2,
    SEL_POLAR  = 3'd3,
    SEL_TRIG   = 3'd4,
    SEL_MASKED = 3'd5,
    SEL_PRIO   = 3'd6,
    SEL_INDEX  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrStatus;
    logic    wrEnable;
    logic    wrRoute;
    logic    wrPolar;
    logic    wrTrig;
    logic    wrPrio;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/uic_ctrl.sv
module uic_ctrl
  import uic_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);

  regSel_e sel;
  logic    aligned;

  assign sel     = regSel_e'(addr[4:2]);
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = sel;
    if (wrEn && aligned) begin
      strobe.wrStatus = (sel == SEL_STATUS);
      strobe.wrEnable = (sel == SEL_ENABLE);
      strobe.wrRoute  = (sel == SEL_ROUTE);
      strobe.wrPolar  = (sel == SEL_POLAR);
      strobe.wrTrig   = (sel == SEL_TRIG);
      strobe.wrPrio   = (sel == SEL_PRIO);
    end
  end

endmodule

// File: rtl/uic_datapath.sv
module uic_datapath
  import uic_pkg::*;
#(
  parameter int          NSRC     = 32,
  parameter logic [31:0] RSV_MASK = 32'h0000_7000,
  parameter int          IDX_W    = $clog2(NSRC) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irqIn,
  input  ctrlStrobe_t      strobe,
  input  logic [NSRC-1:0]  wrData,
  output logic [NSRC-1:0]  rdData,
  output logic [NSRC-1:0]  statusQ,
  output logic [NSRC-1:0]  enableQ,
  output logic [NSRC-1:0]  routeQ,
  output logic [IDX_W-1:0] pendIdx,
  output logic             irqNormal,
  output logic             irqCrit
);

  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NSRC);
  localparam logic [NSRC-1:0]  KEEP     = ~RSV_MASK[NSRC-1:0];

  logic [NSRC-1:0] syncA, syncB, prevAct;
  logic [NSRC-1:0] polarQ, trigQ;
  logic            prioQ;
  logic [NSRC-1:0] activeNow, setReq, clearReq, maskedNow;
  logic [IDX_W-1:0] idxLow, idxHigh;

  // two-stage synchronizer, idle high so active-low defaults stay quiet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= '1;
      syncB   <= '1;
      prevAct <= '0;
    end else begin
      syncA   <= irqIn;
      syncB   <= syncA;
      prevAct <= activeNow;
    end
  end

  assign activeNow = ~(syncB ^ polarQ);

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_capture
      assign setReq[g] = KEEP[g] &
                         (trigQ[g] ? (activeNow[g] & ~prevAct[g]) : activeNow[g]);
    end
  endgenerate

  assign clearReq  = strobe.wrStatus ? wrData : '0;
  assign maskedNow = statusQ & enableQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      enableQ <= '0;
      routeQ  <= '1;
      polarQ  <= '0;
      trigQ   <= '0;
      prioQ   <= 1'b1;
    end else begin
      statusQ <= (statusQ | setReq) & ~clearReq & KEEP;
      if (strobe.wrEnable) enableQ <= wrData;
      if (strobe.wrRoute)  routeQ  <= wrData;
      if (strobe.wrPolar)  polarQ  <= wrData;
      if (strobe.wrTrig)   trigQ   <= wrData;
      if (strobe.wrPrio)   prioQ   <= wrData[0];
    end
  end

  // bit p carries source NSRC-1-p
  always_comb begin
    idxLow  = NONE_IDX;
    idxHigh = NONE_IDX;
    for (int p = 0; p < NSRC; p++) begin
      if (maskedNow[p]) idxLow = IDX_W'(NSRC - 1 - p);
    end
    for (int p = NSRC - 1; p >= 0; p--) begin
      if (maskedNow[p]) idxHigh = IDX_W'(NSRC - 1 - p);
    end
  end

  assign pendIdx = prioQ ? idxLow : idxHigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqNormal <= 1'b0;
      irqCrit   <= 1'b0;
    end else begin
      irqNormal <= |(maskedNow & routeQ);
      irqCrit   <= |(maskedNow & ~routeQ);
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = statusQ;
      SEL_ENABLE: rdData = enableQ;
      SEL_ROUTE:  rdData = routeQ;
      SEL_POLAR:  rdData = polarQ;
      SEL_TRIG:   rdData = trigQ;
      SEL_MASKED: rdData = maskedNow;
      SEL_PRIO:   rdData = NSRC'(prioQ);
      SEL_INDEX:  rdData = NSRC'(pendIdx);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/uic_top.sv
module uic_top
  import uic_pkg::*;
#(
  parameter int          NSRC     = 32,
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] RSV_MASK = 32'h0000_7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irqIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wrData,
  output logic [NSRC-1:0]   rdData,
  output logic              irqNormal,
  output logic              irqCrit
);

  localparam int IDX_W = $clog2(NSRC) + 1;

  ctrlStrobe_t      strobe;
  logic [NSRC-1:0]  statusQ, enableQ, routeQ;
  logic [IDX_W-1:0] pendIdx;

  uic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  uic_datapath #(.NSRC(NSRC), .RSV_MASK(RSV_MASK), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqIn     (irqIn),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdData    (rdData),
    .statusQ   (statusQ),
    .enableQ   (enableQ),
    .routeQ    (routeQ),
    .pendIdx   (pendIdx),
    .irqNormal (irqNormal),
    .irqCrit   (irqCrit)
  );

endmodule

// File: rtl/uic_checker.sv
module uic_checker #(
  parameter int          NSRC     = 32,
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] RSV_MASK = 32'h0000_7000,
  parameter int          IDX_W    = $clog2(NSRC) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wrData,
  input logic [NSRC-1:0]   statusQ,
  input logic [NSRC-1:0]   enableQ,
  input logic [NSRC-1:0]   routeQ,
  input logic [IDX_W-1:0]  pendIdx,
  input logic              irqNormal,
  input logic              irqCrit
);

  logic statusWrite;
  assign statusWrite = wrEn && (addr == '0);

  // R7: reserved sources never hold a request
  a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ & RSV_MASK[NSRC-1:0]) == '0);

  // R3: written ones are clear after the write edge
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    statusWrite |=> ((statusQ & $past(wrData)) == '0));

  // R3: without a status write no held bit drops
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !statusWrite |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R9: normal output follows routed masked bits one clock later
  a_r9_normal_route: assert property (@(posedge clk) disable iff (!rst_n)
    (|(statusQ & enableQ & routeQ)) |=> irqNormal);
  a_r9_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(statusQ & enableQ & routeQ)) |=> !irqNormal);

  // R9: critical output follows the other routing
  a_r9_crit_route: assert property (@(posedge clk) disable iff (!rst_n)
    (|(statusQ & enableQ & ~routeQ)) |=> irqCrit);
  a_r9_crit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(statusQ & enableQ & ~routeQ)) |=> !irqCrit);

  // R10: index reads the none code exactly when nothing masked is pending
  a_r10_none_code: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusQ & enableQ) == '0) == (pendIdx == IDX_W'(NSRC)));

endmodule

bind uic_top uic_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W), .RSV_MASK(RSV_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .statusQ   (statusQ),
  .enableQ   (enableQ),
  .routeQ    (routeQ),
  .pendIdx   (pendIdx),
  .irqNormal (irqNormal),
  .irqCrit   (irqCrit)
);

// File: tb/uic_top_test.sv
`timescale 1ns/1ps
module uic_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irqIn = 32'hFFFF_FFFF;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = 5'h00;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        irqNormal, irqCrit;

  int nVec  = 0;
  int nFail = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  uic_top uut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqNormal(irqNormal), .irqCrit(irqCrit)
  );

  // op: 0 write, 1 read-compare, 2 drive inputs and wait 4 clocks, 3 compare {crit,normal}
  localparam int NV = 58;
  localparam logic [42:0] VECS [NV] = '{
    {2'd1, 5'h00, 32'h0000_0000, 4'd2},  // R2 status clear
    {2'd2, 5'h00, 32'hFFFF_FFFE, 4'd0},  // source 31 active low
    {2'd1, 5'h00, 32'h0000_0001, 4'd1},  // R1 R4 source 31 at bit 0
    {2'd1, 5'h14, 32'h0000_0000, 4'd8},  // R8 nothing enabled
    {2'd1, 5'h1C, 32'h0000_0020, 4'd10}, // R10 none code
    {2'd3, 5'h00, 32'h0000_0000, 4'd9},  // R9 quiet
    {2'd0, 5'h04, 32'hFFFF_FFFF, 4'd0},
    {2'd1, 5'h14, 32'h0000_0001, 4'd8},  // R8
    {2'd1, 5'h1C, 32'h0000_001F, 4'd10}, // R10
    {2'd3, 5'h00, 32'h0000_0001, 4'd9},  // R9 normal
    {2'd0, 5'h00, 32'h0000_0001, 4'd0},  // clear while still active
    {2'd1, 5'h00, 32'h0000_0000, 4'd3},  // R3 cleared
    {2'd1, 5'h00, 32'h0000_0001, 4'd4},  // R4 re-set
    {2'd2, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd1, 5'h00, 32'h0000_0001, 4'd3},  // R3 held after input drops
    {2'd0, 5'h00, 32'hFFFF_FFFE, 4'd0},  // zeros leave bit 0 alone
    {2'd1, 5'h00, 32'h0000_0001, 4'd3},  // R3
    {2'd0, 5'h01, 32'h0000_0001, 4'd0},  // misaligned write
    {2'd1, 5'h00, 32'h0000_0001, 4'd12}, // R12 ignored
    {2'd0, 5'h00, 32'h0000_0001, 4'd0},
    {2'd1, 5'h03, 32'h0000_0000, 4'd3},  // R3 cleared (R12 low bits ignored on read)
    {2'd0, 5'h08, 32'hFFFF_FFFE, 4'd0},  // source 31 to critical
    {2'd2, 5'h00, 32'hFFFF_FFFE, 4'd0},
    {2'd3, 5'h00, 32'h0000_0002, 4'd9},  // R9 critical
    {2'd2, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd0, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd1, 5'h00, 32'h0000_0000, 4'd3},
    {2'd1, 5'h00, 32'h0000_0000, 4'd3},
    {2'd3, 5'h00, 32'h0000_0000, 4'd9},  // R9
    {2'd0, 5'h10, 32'h0000_0001, 4'd0},  // source 31 edge
    {2'd2, 5'h00, 32'hFFFF_FFFE, 4'd0},  // falling edge
    {2'd1, 5'h00, 32'h0000_0001, 4'd5},  // R5 R6 falling captured
    {2'd0, 5'h00, 32'h0000_0001, 4'd0},
    {2'd1, 5'h00, 32'h0000_0000, 4'd5},  // R5
    {2'd1, 5'h00, 32'h0000_0000, 4'd5},  // R5 stays clear while held
    {2'd2, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd1, 5'h00, 32'h0000_0000, 4'd6},  // R6 rising ignored when low active
    {2'd0, 5'h0C, 32'h0000_0001, 4'd0},  // active high
    {2'd0, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd1, 5'h00, 32'h0000_0000, 4'd5},
    {2'd2, 5'h00, 32'hFFFF_FFFE, 4'd0},
    {2'd1, 5'h00, 32'h0000_0000, 4'd6},  // R6 falling ignored
    {2'd2, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd1, 5'h00, 32'h0000_0001, 4'd6},  // R6 rising captured
    {2'd0, 5'h10, 32'h0000_0000, 4'd0},
    {2'd0, 5'h0C, 32'h0000_0000, 4'd0},
    {2'd0, 5'h00, 32'hFFFF_FFFF, 4'd0},
    {2'd0, 5'h08, 32'hFFFF_FFFF, 4'd0},
    {2'd2, 5'h00, 32'h0000_0000, 4'd0},  // every source active
    {2'd1, 5'h00, 32'hFFFF_8FFF, 4'd7},  // R7 reserved stay 0
    {2'd1, 5'h1C, 32'h0000_0000, 4'd10}, // R10 source 0 first
    {2'd0, 5'h18, 32'h0000_0000, 4'd0},
    {2'd1, 5'h1C, 32'h0000_001F, 4'd10}, // R10 reversed
    {2'd0, 5'h04, 32'h0400_0800, 4'd0},  // sources 5 and 20
    {2'd1, 5'h1C, 32'h0000_0014, 4'd10}, // R10 -> 20
    {2'd0, 5'h18, 32'h0000_0001, 4'd0},
    {2'd1, 5'h1C, 32'h0000_0005, 4'd10}, // R10 -> 5
    {2'd0, 5'h14, 32'hFFFF_FFFF, 4'd0}   // write to read-only view
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input int req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1 chk(req, rdData, exp);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rdChk(2, 5'h00, 32'h0);
    rdChk(2, 5'h04, 32'h0);
    rdChk(2, 5'h08, 32'hFFFF_FFFF);
    rdChk(2, 5'h0C, 32'h0);
    rdChk(2, 5'h10, 32'h0);
    rdChk(2, 5'h18, 32'h1);
    rdChk(2, 5'h1C, 32'd32);
    chk(2, {30'h0, irqCrit, irqNormal}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [31:0] d;
      int          rq;
      op = VECS[i][42:41];
      a  = VECS[i][40:36];
      d  = VECS[i][35:4];
      rq = int'(VECS[i][3:0]);
      case (op)
        2'd0: wrReg(a, d);
        2'd1: rdChk(rq, a, d);
        2'd2: begin irqIn = d; repeat (4) @(negedge clk); end
        default: begin #1 chk(rq, {30'h0, irqCrit, irqNormal}, d); @(negedge clk); end
      endcase
    end

    // R8: the read-only view kept its value
    rdChk(8, 5'h14, 32'h0400_0800);
    // R7: enabling only reserved sources yields nothing
    wrReg(5'h04, 32'h0000_7000);
    rdChk(7, 5'h14, 32'h0);
    rdChk(7, 5'h1C, 32'd32);

    // R11: three-edge latency on source 0 (bit 31), level, active low
    irqIn = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    wrReg(5'h00, 32'hFFFF_FFFF);
    addr = 5'h00;
    irqIn = 32'h7FFF_FFFF;
    @(negedge clk); #1 chk(11, {31'h0, rdData[31]}, 32'h0);
    @(negedge clk); #1 chk(11, {31'h0, rdData[31]}, 32'h0);
    @(negedge clk); #1 chk(11, {31'h0, rdData[31]}, 32'h1);

    // R2: reset from a dirty state
    @(negedge clk);
    wrReg(5'h04, 32'hFFFF_FFFF);
    wrReg(5'h0C, 32'h0000_0005);
    wrReg(5'h18, 32'h0000_0000);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rdChk(2, 5'h00, 32'h0);
    rdChk(2, 5'h04, 32'h0);
    rdChk(2, 5'h0C, 32'h0);
    rdChk(2, 5'h18, 32'h1);
    chk(2, {30'h0, irqCrit, irqNormal}, 32'h0);

    finishRun();
  end

endmodule